// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block keeps a synchronous DRAM refreshed. A free-running interval timer adds one owed refresh every refresh interval. While refreshes are owed, the block asks the main command arbiter for the bus. Once the arbiter grants it, the block does three things in order:

- It closes any open bank with a precharge-all command.
- It issues an auto-refresh command.
- It holds the bus with no-operation cycles until the refresh cycle time has passed.

Up to a parameterized number of refreshes may be postponed. When the owed count reaches that limit, an urgent flag asks the arbiter to put refresh ahead of user traffic.

A sleep request takes the memory into self-refresh. The block issues the refresh strobe pattern with clock enable dropping low, and it holds clock enable low while the request stays high. When the request falls, it raises clock enable during a no-operation cycle. It then keeps the bus for the refresh cycle time before it hands the bus back. All timing limits are given in nanoseconds and are converted to cycles from the clock-period parameter.

Top module: `refsched_top`

## Requirements
- R1: During reset, and right after it, the command is deselect (cs_n, ras_n, cas_n, we_n all 1), cke_o is 1, and arb_req_o and ref_urgent_o are 0.
- R2: The owed-refresh count grows by one every TREFI cycles, where TREFI is the ceiling of TREFI_NS divided by the clock period. After reset is released, arb_req_o rises exactly TREFI cycles later.
- R3: While the block is idle and arb_gnt_i is low, no command is driven: the strobes stay deselect.
- R4: Auto refresh is cs_n=0, ras_n=0, cas_n=0, we_n=1, with cke_o high in that cycle and in the cycle before it.
- R5: If bank_open_i is high when a grant is taken, a precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10_o=1) is issued first. The refresh follows exactly TRP cycles later.
- R6: With no bank open, the refresh is issued in the first cycle after the grant is sampled.
- R7: After a refresh, the block drives no-operation (cs_n=0, others 1) for TRFC−1 cycles, keeping arb_req_o high, then returns to deselect. TRFC is the refresh cycle time in cycles.
- R8: Each refresh lowers the owed count by one. The count saturates at POSTPONE_MAX, and ref_urgent_o is high exactly when the count equals POSTPONE_MAX.
- R9: With sleep_req_i and a grant, the block issues the refresh strobes with cke_o low. It then keeps cke_o low and the strobes deselect while sleep_req_i stays high.
- R10: When sleep_req_i falls during self-refresh, cke_o rises in a no-operation cycle. arb_req_o stays high for TRFC−1 cycles counted from that cycle.
- R11: Self-refresh clears the owed count and restarts the interval, so arb_req_o next rises TREFI cycles after the block returns to idle.
- R12: When a sleep request and owed refreshes are both present at grant, self-refresh entry is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arb_gnt_i | input | 1 | Bus grant from the command arbiter |
| bank_open_i | input | 1 | At least one bank has an open row |
| sleep_req_i | input | 1 | Request to enter and stay in self-refresh |
| arb_req_o | output | 1 | Bus request to the arbiter, held through a whole sequence |
| ref_urgent_o | output | 1 | Owed refreshes have reached the postponement limit |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| a10_o | output | 1 | Address bit 10, high for precharge-all |

## Verification
The assertions check several rules on every cycle:
- cke is high in the cycle before any auto refresh.
- No command other than no-operation follows a refresh or a self-refresh exit within the refresh cycle time.
- The exit cycle carries a no-operation.
- cke stays low while sleep is requested.
- The owed count never passes its limit and never wraps.

Only the bench scenarios can show the rest:
- the exact interval period and its restart after self-refresh;
- the precharge-to-refresh distance;
- saturation seen through the urgent flag after one refresh;
- the priority of sleep over owed refreshes.

// File: rtl/refsched_pkg.sv
`timescale 1ns/1ps
package refsched_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STB_DESEL   = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam strobe_t STB_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam strobe_t STB_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam strobe_t STB_PRECHG  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_PRE_WAIT,
        PH_REF,
        PH_RFC_WAIT,
        PH_SR_ENTER,
        PH_SR_HOLD,
        PH_SR_EXIT
    } phase_e;

    // Ceiling conversion of a nanosecond limit into clock cycles, with a floor.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period_ps,
                                              input int unsigned min_cyc);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < min_cyc) ? min_cyc : c;
    endfunction

endpackage

// File: rtl/refsched_interval.sv
`timescale 1ns/1ps
module refsched_interval #(
    parameter int unsigned PERIOD_CYC = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic tick_o
);
    localparam int unsigned W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [W-1:0] LAST_V = W'(PERIOD_CYC - 1);

    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST_V) && !hold_i;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_V) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_INTERVAL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_V);  // R2
endmodule

// File: rtl/refsched_debt.sv
`timescale 1ns/1ps
module refsched_debt #(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic owed_o,
    output logic urgent_o
);
    localparam int unsigned W = $clog2(MAX_OWED + 1);
    localparam logic [W-1:0] MAX_V = W'(MAX_OWED);

    logic [W-1:0] count_q;

    assign owed_o   = (count_q != '0);
    assign urgent_o = (count_q == MAX_V);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_q <= '0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10: if (count_q != MAX_V) count_q <= count_q + 1'b1;
                2'b01: if (count_q != '0)    count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_PENDING_CAP: assert property (@(posedge clk) disable iff (rst)
        count_q <= MAX_V);  // R8
    AST_PENDING_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count_q == MAX_V && inc_i && !dec_i && !clear_i) |=> (count_q == MAX_V));  // R8
endmodule

// File: rtl/refsched_wait.sv
`timescale 1ns/1ps
module refsched_wait #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    assign last_o = (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));  // R7
endmodule

// File: rtl/refsched_top.sv
`timescale 1ns/1ps
module refsched_top
    import refsched_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned TREFI_NS      = 15600,
    parameter int unsigned TRP_NS        = 20,
    parameter int unsigned TRFC_NS       = 70,
    parameter int unsigned POSTPONE_MAX  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_gnt_i,
    input  logic bank_open_i,
    input  logic sleep_req_i,
    output logic arb_req_o,
    output logic ref_urgent_o,
    output logic cs_n_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic cke_o,
    output logic a10_o
);
    localparam int unsigned TREFI_CYC = ns_to_cyc(TREFI_NS, CLK_PERIOD_PS, 2);
    localparam int unsigned TRP_CYC   = ns_to_cyc(TRP_NS,   CLK_PERIOD_PS, 2);
    localparam int unsigned TRFC_CYC  = ns_to_cyc(TRFC_NS,  CLK_PERIOD_PS, 2);
    localparam int unsigned WAIT_MAX  = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int unsigned WAIT_W    = $clog2(WAIT_MAX + 1);
    localparam int unsigned GAP_W     = $clog2(TRFC_CYC + 1);

    phase_e        phase_q, phase_d;
    logic          to_sleep_q;
    logic          tick, owed, urgent, wait_last;
    logic          sr_zone, wait_load;
    logic [WAIT_W-1:0] wait_val;
    strobe_t       stb;
    logic          cke;

    assign sr_zone = (phase_q == PH_SR_ENTER) || (phase_q == PH_SR_HOLD) ||
                     (phase_q == PH_SR_EXIT);

    refsched_interval #(.PERIOD_CYC(TREFI_CYC)) u_interval (
        .clk    (clk),
        .rst    (rst),
        .hold_i (sr_zone),
        .tick_o (tick)
    );

    refsched_debt #(.MAX_OWED(POSTPONE_MAX)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (sr_zone),
        .inc_i    (tick),
        .dec_i    (phase_q == PH_REF),
        .owed_o   (owed),
        .urgent_o (urgent)
    );

    assign wait_load = (phase_q == PH_PRE) || (phase_q == PH_REF) ||
                       (phase_q == PH_SR_HOLD && !sleep_req_i);
    assign wait_val  = (phase_q == PH_PRE) ? WAIT_W'(TRP_CYC - 1) : WAIT_W'(TRFC_CYC - 1);

    refsched_wait #(.W(WAIT_W)) u_wait (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wait_load),
        .load_val_i (wait_val),
        .last_o     (wait_last)
    );

    // Sequencer: sleep outranks owed refreshes at grant; open banks are closed first.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (arb_gnt_i && (sleep_req_i || owed)) begin
                    if (bank_open_i)      phase_d = PH_PRE;
                    else if (sleep_req_i) phase_d = PH_SR_ENTER;
                    else                  phase_d = PH_REF;
                end
            end
            PH_PRE:      phase_d = PH_PRE_WAIT;
            PH_PRE_WAIT: if (wait_last) phase_d = to_sleep_q ? PH_SR_ENTER : PH_REF;
            PH_REF:      phase_d = PH_RFC_WAIT;
            PH_RFC_WAIT: if (wait_last) phase_d = PH_IDLE;
            PH_SR_ENTER: phase_d = PH_SR_HOLD;
            PH_SR_HOLD:  if (!sleep_req_i) phase_d = PH_SR_EXIT;
            PH_SR_EXIT:  if (wait_last) phase_d = PH_IDLE;
            default:     phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            to_sleep_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE) to_sleep_q <= sleep_req_i;
        end
    end

    // Command decode straight from the phase register.
    always_comb begin
        stb   = STB_DESEL;
        cke   = 1'b1;
        a10_o = 1'b0;
        unique case (phase_q)
            PH_IDLE:     stb = STB_DESEL;
            PH_PRE:      begin stb = STB_PRECHG; a10_o = 1'b1; end
            PH_PRE_WAIT: stb = STB_NOP;
            PH_REF:      stb = STB_REFRESH;
            PH_RFC_WAIT: stb = STB_NOP;
            PH_SR_ENTER: begin stb = STB_REFRESH; cke = 1'b0; end
            PH_SR_HOLD:  begin stb = STB_DESEL;   cke = 1'b0; end
            PH_SR_EXIT:  stb = STB_NOP;
            default:     stb = STB_DESEL;
        endcase
    end

    assign cs_n_o       = stb.cs_n;
    assign ras_n_o      = stb.ras_n;
    assign cas_n_o      = stb.cas_n;
    assign we_n_o       = stb.we_n;
    assign cke_o        = cke;
    assign arb_req_o    = (phase_q != PH_IDLE) || sleep_req_i || owed;
    assign ref_urgent_o = urgent;

    // Checker support: cycles since the last refresh or self-refresh exit.
    logic [GAP_W-1:0] gap_q;
    logic             cke_d_q;
    logic             cmd_issued;

    assign cmd_issued = !cs_n_o && !(ras_n_o && cas_n_o && we_n_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= GAP_W'(TRFC_CYC);
            cke_d_q <= 1'b1;
        end else begin
            cke_d_q <= cke_o;
            if ((stb == STB_REFRESH) || (cke_o && !cke_d_q)) gap_q <= GAP_W'(1);
            else if (gap_q != GAP_W'(TRFC_CYC))              gap_q <= gap_q + 1'b1;
        end
    end

    AST_REF_CKE_PRIOR: assert property (@(posedge clk) disable iff (rst)
        (stb == STB_REFRESH && cke_o) |-> $past(cke_o));  // R4
    AST_RFC_SPACING: assert property (@(posedge clk) disable iff (rst)
        cmd_issued |-> (gap_q == GAP_W'(TRFC_CYC)));  // R7
    AST_EXIT_IS_NOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_o) |-> (stb == STB_NOP));  // R10
    AST_SLEEP_HOLDS_CKE: assert property (@(posedge clk) disable iff (rst)
        (!cke_o && sleep_req_i) |=> !cke_o);  // R9
endmodule

// File: tb/refsched_top_tb_top.sv
`timescale 1ns/1ps
module refsched_top_tb_top;
    localparam int CLK_PS  = 5000;
    localparam int REFI_NS = 200;
    localparam int RP_NS   = 20;
    localparam int RFC_NS  = 70;
    localparam int PMAX    = 4;
    localparam int REFI_C  = (REFI_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RP_C    = (RP_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RFC_C   = (RFC_NS * 1000 + CLK_PS - 1) / CLK_PS;

    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_REF   = 4'b0001;
    localparam logic [3:0] C_PRE   = 4'b0010;

    // Stimulus table: bank-open flag and expected grant-to-refresh distance.
    localparam int VEC_N = 4;
    localparam bit VEC_OPEN [VEC_N] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam int VEC_DLY  [VEC_N] = '{1, 1 + RP_C, 1 + RP_C, 1};

    logic clk = 1'b0, rst = 1'b1;
    logic gnt = 1'b0, bank_open = 1'b0, sleep = 1'b0;
    logic req, urgent, cs_n, ras_n, cas_n, we_n, cke, a10;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    refsched_top #(
        .CLK_PERIOD_PS(CLK_PS), .TREFI_NS(REFI_NS), .TRP_NS(RP_NS),
        .TRFC_NS(RFC_NS), .POSTPONE_MAX(PMAX)
    ) dut_i (
        .clk(clk), .rst(rst), .arb_gnt_i(gnt), .bank_open_i(bank_open),
        .sleep_req_i(sleep), .arb_req_o(req), .ref_urgent_o(urgent),
        .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .cke_o(cke), .a10_o(a10)
    );

    function automatic logic [3:0] cmd();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        bit bad;
        int n, hi, lo;
        logic [3:0] first_cmd;
        logic first_a10, cke_prev;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd() == C_DESEL, "R1 strobes", cmd(), C_DESEL);
        chk(cke == 1'b1, "R1 cke", cke, 1);
        chk(req == 1'b0 && urgent == 1'b0, "R1 req/urgent", {req, urgent}, 0);
        rst = 1'b0;

        // R2: first request exactly one interval after reset release
        repeat (REFI_C - 1) @(posedge clk);
        @(negedge clk);
        chk(req == 1'b0, "R2 before interval", req, 0);
        @(posedge clk); @(negedge clk);
        chk(req == 1'b1, "R2 at interval", req, 1);

        // R3 and R8: no grant, debt grows to its limit and saturates
        bad = 1'b0;
        for (int e = REFI_C + 1; e <= REFI_C * (PMAX + 2) + 10; e++) begin
            @(posedge clk); @(negedge clk);
            if (cs_n == 1'b0) bad = 1'b1;
            if (e == REFI_C * PMAX - 1) chk(urgent == 1'b0, "R8 urgent before limit", urgent, 0);
            if (e == REFI_C * PMAX)     chk(urgent == 1'b1, "R8 urgent at limit", urgent, 1);
        end
        chk(!bad, "R3 no command without grant", bad, 0);

        gnt = 1'b1;
        @(negedge clk);
        chk(cmd() == C_REF, "R6 refresh right after grant", cmd(), C_REF);
        gnt = 1'b0;
        repeat (19) @(negedge clk);
        chk(urgent == 1'b0 && req == 1'b1, "R8 saturated then one refresh", {urgent, req}, 1);

        // Table walk: refresh sequences with and without open banks
        for (int v = 0; v < VEC_N; v++) begin
            bank_open = VEC_OPEN[v];
            n = 0;
            while (!req && n < 4 * REFI_C) begin @(negedge clk); n++; end
            gnt = 1'b1;
            n = 0; first_cmd = C_DESEL; first_a10 = 1'b0; cke_prev = cke;
            do begin
                cke_prev = cke;
                @(negedge clk);
                n++;
                if (n == 1) begin first_cmd = cmd(); first_a10 = a10; end
            end while (cmd() != C_REF && n < 40);
            gnt = 1'b0;
            chk(n == VEC_DLY[v], VEC_OPEN[v] ? "R5 precharge-to-refresh distance" :
                                               "R6 grant-to-refresh distance", n, VEC_DLY[v]);
            chk(cke_prev && cke, "R4 cke high before and at refresh", {cke_prev, cke}, 3);
            if (VEC_OPEN[v])
                chk(first_cmd == C_PRE && first_a10, "R5 precharge-all first",
                    {first_cmd, first_a10}, {C_PRE, 1'b1});
            bad = 1'b0;
            for (int k = 0; k < RFC_C - 1; k++) begin
                @(negedge clk);
                if (!(cmd() == C_NOP && cke && req)) bad = 1'b1;
            end
            chk(!bad, "R7 nop window held", bad, 0);
            @(negedge clk);
            chk(cmd() == C_DESEL, "R7 release after window", cmd(), C_DESEL);
            bank_open = 1'b0;
        end

        // Self-refresh with owed refreshes present
        n = 0;
        while (!req && n < 4 * REFI_C) begin @(negedge clk); n++; end
        sleep = 1'b1; gnt = 1'b1;
        @(negedge clk);
        chk(cmd() == C_REF && cke == 1'b0, "R12 sleep wins / R9 entry", {cmd(), cke}, {C_REF, 1'b0});
        bad = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!(cke == 1'b0 && cmd() == C_DESEL)) bad = 1'b1;
        end
        chk(!bad, "R9 cke held low", bad, 0);
        sleep = 1'b0;
        @(negedge clk);
        chk(cke == 1'b1 && cmd() == C_NOP, "R10 exit with nop", {cke, cmd()}, {1'b1, C_NOP});
        gnt = 1'b0;
        hi = 0;
        while (req && hi < 1000) begin hi++; @(negedge clk); end
        chk(hi == RFC_C - 1, "R10 recovery hold", hi, RFC_C - 1);
        lo = 0;
        while (!req && lo < 1000) begin lo++; @(negedge clk); end
        chk(lo == REFI_C, "R11 interval restarted", lo, REFI_C);

        done = 1'b1;
        report();
        $finish;
    end
endmodule